// File: doc/BRIEF.md
# DMA Channel Control and Abort Sequencer

This block is the control core of one DMA channel. Software-owned mode bits (start, continue, abort) and a chaining-mode flag come in. Two status bits, busy and error, go out, along with a decoded channel-state code. Toward the shared transfer engine it issues a one-cycle launch pulse for each sub-block. The engine answers with a sub-block-done pulse, and a flag marks the final sub-block. The engine also reports faults. Two pulses, one on each bus request issued and one on each response retired, keep an outstanding-transaction count.

An abort is taken only on a rising edge of the abort bit. The running sub-block is allowed to finish and nothing new is launched. Busy stays set until the outstanding count has returned to zero. Normal completion and error halts use the same drain rule. Software can also pause the channel by clearing start, and resume it by setting start again.

FSM states:
- IDLE: not busy.
- KICK: launch pulse.
- ACTIVE: sub-block running.
- FINISH: abort seen, current sub-block still running.
- SWHALT: software pause.
- DRAIN: waiting for the outstanding count to reach zero.
- ERR_DRAIN: error, draining.
- ERR_HALT: error, stopped.

Transitions:
- IDLE→KICK on a start rise, or on a continue rise when start is set and chaining is on.
- KICK→ACTIVE.
- ACTIVE→KICK on a non-final done while start is set.
- ACTIVE→SWHALT on a non-final done while start is clear.
- ACTIVE→DRAIN on a final done, or on an abort rise in the same cycle as a done.
- ACTIVE→FINISH on an abort rise without a done. KICK→FINISH on an abort rise.
- FINISH→DRAIN on a done.
- SWHALT→KICK when start is set again.
- SWHALT→DRAIN on an abort rise.
- DRAIN→IDLE when the count is zero.
- Any busy state other than ERR_DRAIN → ERR_DRAIN on a fault.
- ERR_DRAIN→ERR_HALT when the count is zero.
- ERR_HALT→KICK on a start rise.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, stat_busy=0, stat_err=0, eng_go=0 and chan_state=0.
- R2: A 0→1 edge of cfg_start while not busy and error-free raises eng_go for exactly one cycle, in the cycle after the edge is sampled, and sets stat_busy.
- R3: A non-final eng_sb_done while start is set relaunches: eng_go=1 the next cycle. A final done (eng_sb_last=1) launches nothing, and the channel completes.
- R4: Abort is recognised only on a 0→1 edge of cfg_abort. Holding cfg_abort at 1 through a new start has no effect: sub-blocks keep being relaunched.
- R5: After an abort edge, the sub-block in progress runs to its done pulse, and eng_go never rises again for that run.
- R6: stat_busy clears only after the outstanding count (a 4-bit saturating counter) is zero. A retire with the count at 0 leaves it at 0. An issue and a retire in the same cycle leave it unchanged.
- R7: An abort edge in the same cycle as eng_sb_done goes straight to draining. With nothing outstanding, busy clears one cycle later.
- R8: Clearing cfg_start while running pauses the channel at the next sub-block boundary, with busy held and no launch. Setting cfg_start again relaunches. An abort edge while paused drains and clears busy.
- R9: eng_fault while busy sets stat_err. Busy stays set until the outstanding count is zero and then clears, with error kept. Continue has no effect while error is set. A new start edge clears error and launches.
- R10: A continue edge with start set and not busy launches only when chain_en=1. With chain_en=0 it has no effect.
- R11: chan_state decodes the start, busy, error and continue bits as follows:
  - 0: idle (start=0, busy=0, error=0).
  - 1: ready or done (start=1, busy=0, error=0, and no chained continue).
  - 2: continue requested (start=1, busy=0, error=0, continue=1, chain_en=1).
  - 3: running (start=1, busy=1, error=0).
  - 4: software-halted (start=0, busy=1, error=0).
  - 5: error halting (busy=1, error=1).
  - 6: error halted (busy=0, error=1).
- R12: A fault and an abort edge in the same cycle resolve as an error: stat_err=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_en | input | 1 | 1 = chaining mode, 0 = direct mode |
| cfg_start | input | 1 | Software start bit (level) |
| cfg_cont | input | 1 | Software continue bit (edge used) |
| cfg_abort | input | 1 | Software abort bit (edge used) |
| eng_go | output | 1 | One-cycle launch of a sub-block |
| eng_sb_done | input | 1 | Pulse: current sub-block finished |
| eng_sb_last | input | 1 | Qualifies eng_sb_done as the final sub-block |
| eng_fault | input | 1 | Pulse: transfer error |
| bus_issue | input | 1 | Pulse: one bus transaction issued |
| bus_retire | input | 1 | Pulse: one bus transaction completed |
| stat_busy | output | 1 | Channel busy status |
| stat_err | output | 1 | Transfer error status |
| chan_state | output | 3 | Decoded channel state code (R11) |

## Verification
Two pairs of events can land in the same cycle. The first pair is an abort edge and the engine's sub-block-done pulse: the bench drives both in one cycle and expects a direct move to draining, with no launch and busy clearing one cycle later. The second pair is an issue and a retire on the outstanding counter, which the bench drives together after first attempting a retire at zero. The count cannot be read at the ports, so it is judged through drain timing. After a single further issue, busy must hold until exactly one retire arrives and then drop. A wrapped or drifted count would keep busy high.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_KICK      = 3'd1,
        S_ACTIVE    = 3'd2,
        S_FINISH    = 3'd3,
        S_SWHALT    = 3'd4,
        S_DRAIN     = 3'd5,
        S_ERR_DRAIN = 3'd6,
        S_ERR_HALT  = 3'd7
    } fsm_t;

    typedef enum logic [2:0] {
        CS_IDLE        = 3'd0,
        CS_READY       = 3'd1,
        CS_CONT        = 3'd2,
        CS_RUN         = 3'd3,
        CS_SWHALT      = 3'd4,
        CS_ERR_HALTING = 3'd5,
        CS_ERR_HALTED  = 3'd6,
        CS_RSVD        = 3'd7
    } chan_state_t;

endpackage

// File: rtl/dmac_rise_det.sv
module dmac_rise_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    // R4: an edge is a single-cycle event per lane
    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/dmac_inflight_ctr.sv
module dmac_inflight_ctr #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic zero
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign zero = (cnt_q == '0);

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));

    a_r6_paired_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));

endmodule

// File: rtl/dmac_chan_fsm.sv
module dmac_chan_fsm
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chain_en,
    input  logic start_lvl,
    input  logic start_rise,
    input  logic cont_rise,
    input  logic abort_rise,
    input  logic sb_done,
    input  logic sb_last,
    input  logic fault,
    input  logic drained,
    output logic go,
    output logic busy,
    output logic err
);
    fsm_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_rise)                              state_d = S_KICK;
                else if (cont_rise && chain_en && start_lvl) state_d = S_KICK;
            end
            S_KICK: begin
                if (fault)           state_d = S_ERR_DRAIN;
                else if (abort_rise) state_d = S_FINISH;
                else                 state_d = S_ACTIVE;
            end
            S_ACTIVE: begin
                if (fault)                        state_d = S_ERR_DRAIN;
                else if (abort_rise && sb_done)   state_d = S_DRAIN;
                else if (abort_rise)              state_d = S_FINISH;
                else if (sb_done && sb_last)      state_d = S_DRAIN;
                else if (sb_done && !start_lvl)   state_d = S_SWHALT;
                else if (sb_done)                 state_d = S_KICK;
            end
            S_FINISH: begin
                if (fault)        state_d = S_ERR_DRAIN;
                else if (sb_done) state_d = S_DRAIN;
            end
            S_SWHALT: begin
                if (fault)           state_d = S_ERR_DRAIN;
                else if (abort_rise) state_d = S_DRAIN;
                else if (start_lvl)  state_d = S_KICK;
            end
            S_DRAIN: begin
                if (fault)        state_d = S_ERR_DRAIN;
                else if (drained) state_d = S_IDLE;
            end
            S_ERR_DRAIN: begin
                if (drained) state_d = S_ERR_HALT;
            end
            S_ERR_HALT: begin
                if (start_rise) state_d = S_KICK;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        go   = (state_q == S_KICK);
        busy = (state_q != S_IDLE) && (state_q != S_ERR_HALT);
        err  = (state_q == S_ERR_DRAIN) || (state_q == S_ERR_HALT);
    end

    a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    a_r5_no_kick_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> (state_q != S_KICK));

    a_r6_hold_until_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN && !drained) |=> (state_q == S_DRAIN || state_q == S_ERR_DRAIN));

    a_r9_err_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (err && busy) |=> err);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chain_en,
    input  logic       cfg_start,
    input  logic       cfg_cont,
    input  logic       cfg_abort,
    output logic       eng_go,
    input  logic       eng_sb_done,
    input  logic       eng_sb_last,
    input  logic       eng_fault,
    input  logic       bus_issue,
    input  logic       bus_retire,
    output logic       stat_busy,
    output logic       stat_err,
    output logic [2:0] chan_state
);
    localparam int NEDGE = 3;

    logic [NEDGE-1:0] rise;
    logic             drained;
    chan_state_t      cs;

    dmac_rise_det #(.N(NEDGE)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({cfg_abort, cfg_cont, cfg_start}),
        .rise (rise)
    );

    dmac_inflight_ctr #(.W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (bus_issue),
        .dec  (bus_retire),
        .zero (drained)
    );

    dmac_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chain_en  (chain_en),
        .start_lvl (cfg_start),
        .start_rise(rise[0]),
        .cont_rise (rise[1]),
        .abort_rise(rise[2]),
        .sb_done   (eng_sb_done),
        .sb_last   (eng_sb_last),
        .fault     (eng_fault),
        .drained   (drained),
        .go        (eng_go),
        .busy      (stat_busy),
        .err       (stat_err)
    );

    always_comb begin
        if (stat_err)
            cs = stat_busy ? CS_ERR_HALTING : CS_ERR_HALTED;
        else if (stat_busy)
            cs = cfg_start ? CS_RUN : CS_SWHALT;
        else if (!cfg_start)
            cs = CS_IDLE;
        else if (cfg_cont && chain_en)
            cs = CS_CONT;
        else
            cs = CS_READY;
    end

    assign chan_state = cs;

    a_r11_err_codes: assert property (@(posedge clk) disable iff (!rst_n)
        stat_err |-> (chan_state == 3'd5 || chan_state == 3'd6));

endmodule

// File: tb/dma_chan_ctrl_tb.sv
module dma_chan_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chain_en = 1'b0, cfg_start = 1'b0, cfg_cont = 1'b0, cfg_abort = 1'b0;
    logic       eng_sb_done = 1'b0, eng_sb_last = 1'b0, eng_fault = 1'b0;
    logic       bus_issue = 1'b0, bus_retire = 1'b0;
    logic       eng_go, stat_busy, stat_err;
    logic [2:0] chan_state;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dma_chan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
        .cfg_start(cfg_start), .cfg_cont(cfg_cont), .cfg_abort(cfg_abort),
        .eng_go(eng_go), .eng_sb_done(eng_sb_done), .eng_sb_last(eng_sb_last),
        .eng_fault(eng_fault), .bus_issue(bus_issue), .bus_retire(bus_retire),
        .stat_busy(stat_busy), .stat_err(stat_err), .chan_state(chan_state)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch();
        cfg_start = 1'b0; step();
        cfg_start = 1'b1; step();
        step();
    endtask

    task automatic t_reset();
        chk("R1 busy", stat_busy, 0);
        chk("R1 err", stat_err, 0);
        chk("R1 go", eng_go, 0);
        chk("R1 state", chan_state, 0);
    endtask

    task automatic t_normal();
        cfg_start = 1'b1; step();
        chk("R2 go", eng_go, 1);
        chk("R2 busy", stat_busy, 1);
        chk("R11 running", chan_state, 3);
        step();
        chk("R2 go single", eng_go, 0);
        bus_issue = 1'b1; step(); step(); bus_issue = 1'b0;
        eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        chk("R3 relaunch", eng_go, 1);
        step();
        eng_sb_done = 1'b1; eng_sb_last = 1'b1; step();
        eng_sb_done = 1'b0; eng_sb_last = 1'b0;
        chk("R3 no launch after last", eng_go, 0);
        step();
        chk("R6 busy while pending", stat_busy, 1);
        bus_retire = 1'b1; step(); step(); bus_retire = 1'b0;
        chk("R6 busy until drain seen", stat_busy, 1);
        step();
        chk("R3 complete busy", stat_busy, 0);
        chk("R11 ready", chan_state, 1);
    endtask

    task automatic t_cont();
        chain_en = 1'b0; cfg_cont = 1'b1; step();
        chk("R10 direct cont ignored", stat_busy, 0);
        chk("R11 direct ready", chan_state, 1);
        cfg_cont = 1'b0; step();
        chain_en = 1'b1; cfg_cont = 1'b1;
        #1 chk("R11 cont pending", chan_state, 2);
        step(); cfg_cont = 1'b0;
        chk("R10 chained cont go", eng_go, 1);
        step();
        eng_sb_done = 1'b1; eng_sb_last = 1'b1; step();
        eng_sb_done = 1'b0; eng_sb_last = 1'b0;
        step();
        chk("R10 chained done", stat_busy, 0);
    endtask

    task automatic t_abort();
        launch();
        bus_issue = 1'b1; step(); bus_issue = 1'b0;
        cfg_abort = 1'b1; step();
        chk("R5 busy in finish", stat_busy, 1);
        step();
        chk("R5 no go", eng_go, 0);
        eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        chk("R5 no relaunch", eng_go, 0);
        step();
        chk("R6 abort waits drain", stat_busy, 1);
        bus_retire = 1'b1; step(); bus_retire = 1'b0;
        step();
        chk("R6 abort drained", stat_busy, 0);
        launch();
        step();
        eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        chk("R4 level abort ignored", eng_go, 1);
        step();
        cfg_abort = 1'b0; step();
        cfg_abort = 1'b1; eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        step();
        cfg_abort = 1'b0; step();
    endtask

    task automatic t_abort_done();
        launch();
        cfg_abort = 1'b1; eng_sb_done = 1'b1; step();
        eng_sb_done = 1'b0;
        chk("R7 draining busy", stat_busy, 1);
        chk("R7 no go", eng_go, 0);
        step();
        chk("R7 idle", stat_busy, 0);
        cfg_abort = 1'b0; step();
    endtask

    task automatic t_counter();
        launch();
        bus_retire = 1'b1; step();
        bus_issue = 1'b1; step();
        bus_retire = 1'b0; step();
        bus_issue = 1'b0;
        cfg_abort = 1'b1; eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        step();
        chk("R6 count one held", stat_busy, 1);
        step();
        chk("R6 count one still", stat_busy, 1);
        bus_retire = 1'b1; step(); bus_retire = 1'b0;
        chk("R6 retire seen", stat_busy, 1);
        step();
        chk("R6 no underflow drain", stat_busy, 0);
        cfg_abort = 1'b0; step();
    endtask

    task automatic t_swhalt();
        launch();
        cfg_start = 1'b0; step();
        eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        chk("R8 halted busy", stat_busy, 1);
        chk("R8 halted no go", eng_go, 0);
        chk("R11 swhalt", chan_state, 4);
        step();
        chk("R8 stays halted", stat_busy, 1);
        cfg_start = 1'b1; step();
        chk("R8 resume go", eng_go, 1);
        step();
        cfg_start = 1'b0; eng_sb_done = 1'b1; step(); eng_sb_done = 1'b0;
        cfg_abort = 1'b1; step();
        chk("R8 abort drain busy", stat_busy, 1);
        step();
        chk("R8 abort from halt", stat_busy, 0);
        chk("R11 idle", chan_state, 0);
        cfg_abort = 1'b0; step();
    endtask

    task automatic t_error();
        launch();
        bus_issue = 1'b1; step(); bus_issue = 1'b0;
        eng_fault = 1'b1; step(); eng_fault = 1'b0;
        chk("R9 err set", stat_err, 1);
        chk("R9 busy kept", stat_busy, 1);
        chk("R11 err halting", chan_state, 5);
        cfg_cont = 1'b1; step(); cfg_cont = 1'b0;
        chk("R9 cont ignored", chan_state, 5);
        bus_retire = 1'b1; step(); bus_retire = 1'b0;
        step();
        chk("R9 busy cleared", stat_busy, 0);
        chk("R11 err halted", chan_state, 6);
        cfg_cont = 1'b1; step(); cfg_cont = 1'b0;
        chk("R9 cont no launch", stat_busy, 0);
        cfg_start = 1'b0; step();
        cfg_start = 1'b1; step();
        chk("R9 restart clears err", stat_err, 0);
        chk("R9 restart go", eng_go, 1);
        step();
        cfg_abort = 1'b1; eng_fault = 1'b1; step();
        eng_fault = 1'b0;
        chk("R12 fault beats abort", stat_err, 1);
        step();
        chk("R12 err halted", stat_busy, 0);
        cfg_abort = 1'b0; step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_normal();
        t_cont();
        t_abort();
        t_abort_done();
        t_counter();
        t_swhalt();
        t_error();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule